// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides whether an atomic memory operation may go ahead once its address has been translated. It handles two kinds of atomic operation: a conditional store (compare-and-swap) and an exclusive load/store. Its inputs are the result of address translation, the page permissions, the page's cache attribute class, whether a data cache is built in, and a small atomic control word. From these it either grants the access or reports an exception cause code.

The atomic control word holds one 2-bit policy field for each cacheable class. The page's cache attribute picks one of these fields, and a zero field forbids atomics on that class. Each request is marked by a valid strobe. The verdict appears one clock later, with its own valid flag. Address translation, the memory access itself and exception dispatch all sit outside this block.

Top module: `atom_perm_chk`

## Requirements
- R1: A response is registered. `rsp_valid` is high exactly one cycle after `req_valid` was high, and reset clears `rsp_valid`, `rsp_allow` and `rsp_cause`.
- R2: A nonzero `xlat_code` is reported as the cause, with `rsp_allow` low. This check overrides every other check.
- R3: A conditional store (`op_excl`=0) to a page that is not both readable and writable faults with cause `CAUSE_ST_PROHIB`. No load-prohibited cause is ever produced.
- R4: An exclusive operation (`op_excl`=1) ignores `perm_rd`, `perm_wr` and `is_write`.
- R5: The 2-bit field of `atom_ctl` is chosen by `cache_attr`: 2'b00 (bypass) uses bits [1:0], 2'b01 (write-through) uses bits [3:2], and 2'b10 (write-back) uses bits [5:4].
- R6: When the chosen field is zero, a conditional store faults with `CAUSE_LS_ERR` and an exclusive operation faults with `CAUSE_EXCL_ERR`.
- R7: `cache_attr`=2'b11 (isolate) always faults with `CAUSE_LS_ERR`, whatever `atom_ctl` holds.
- R8: With `dcache_present`=0, every attribute, isolate included, is treated as bypass, so bits [1:0] are used.
- R9: When no check faults, `rsp_allow`=1 and `rsp_cause`=0.
- R10: In a cycle where `rsp_valid` is low, `rsp_allow` and `rsp_cause` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| op_excl | input | 1 | 1 = exclusive access, 0 = conditional store |
| is_write | input | 1 | Write flag of the access |
| xlat_code | input | CAUSE_W | Translation result; 0 means success |
| perm_rd | input | 1 | Page is readable |
| perm_wr | input | 1 | Page is writable |
| cache_attr | input | 2 | Cache attribute class |
| dcache_present | input | 1 | A data cache is configured |
| atom_ctl | input | FIELD_W*N_FIELDS | Atomic control word |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_cause | output | CAUSE_W | Exception cause, 0 when allowed |

## Verification
The bench builds the checker with 2-bit fields, three fields and a 7-bit cause width. Its cause codes are 3, 29 and 70, so a truncated or swapped code cannot go unnoticed. With these values every combination of operation, cache presence, attribute, the whole 64-value control word and both permission bits can be swept. Translation codes up to the top of the 7-bit range are also exercised, and idle gaps are placed between requests.

// File: rtl/atom_chk_pkg.sv
package atom_chk_pkg;
    typedef enum logic [1:0] {
        ATTR_BYPASS = 2'd0,
        ATTR_WTHRU  = 2'd1,
        ATTR_WBACK  = 2'd2,
        ATTR_ISOL   = 2'd3
    } attr_e;

    typedef enum logic {
        OP_CSTORE = 1'b0,
        OP_EXCL   = 1'b1
    } op_e;
endpackage

// File: rtl/atom_field_sel.sv
module atom_field_sel
    import atom_chk_pkg::*;
#(
    parameter int FIELD_W  = 2,
    parameter int N_FIELDS = 3,
    localparam int CTL_W   = FIELD_W * N_FIELDS
) (
    input  logic [1:0]       cache_attr,
    input  logic             dcache_present,
    input  logic [CTL_W-1:0] atom_ctl,
    output logic             field_zero,
    output logic             is_isolate
);
    logic [FIELD_W-1:0] fld [N_FIELDS];
    attr_e              eff_attr;

    // Without a data cache every page behaves as bypass (R8)
    assign eff_attr = dcache_present ? attr_e'(cache_attr) : ATTR_BYPASS;

    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_fld
        assign fld[gi] = atom_ctl[gi*FIELD_W +: FIELD_W];
    end

    // Field index follows the attribute encoding (R5)
    always_comb begin
        field_zero = 1'b0;
        for (int i = 0; i < N_FIELDS; i++) begin
            if (32'(eff_attr) == i) begin
                field_zero = (fld[i] == '0);
            end
        end
    end

    assign is_isolate = (eff_attr == ATTR_ISOL);
endmodule

// File: rtl/atom_fault_pri.sv
module atom_fault_pri
    import atom_chk_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter logic [CAUSE_W-1:0] CAUSE_LS_ERR    = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_ST_PROHIB = 29,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR  = 23
) (
    input  logic               op_excl,
    input  logic [CAUSE_W-1:0] xlat_code,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic               field_zero,
    input  logic               is_isolate,
    output logic               allow,
    output logic [CAUSE_W-1:0] cause
);
    op_e op;
    assign op = op_e'(op_excl);

    always_comb begin
        allow = 1'b0;
        cause = '0;
        if (xlat_code != '0) begin
            cause = xlat_code;                        // R2
        end else if (op == OP_CSTORE && !(perm_rd && perm_wr)) begin
            cause = CAUSE_ST_PROHIB;                  // R3
        end else if (is_isolate) begin
            cause = CAUSE_LS_ERR;                     // R7
        end else if (field_zero) begin
            cause = (op == OP_EXCL) ? CAUSE_EXCL_ERR : CAUSE_LS_ERR; // R6
        end else begin
            allow = 1'b1;                             // R9
        end
    end
endmodule

// File: rtl/atom_perm_chk.sv
module atom_perm_chk
    import atom_chk_pkg::*;
#(
    parameter int FIELD_W  = 2,
    parameter int N_FIELDS = 3,
    parameter int CAUSE_W  = 6,
    parameter logic [CAUSE_W-1:0] CAUSE_LS_ERR    = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_ST_PROHIB = 29,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR  = 23,
    localparam int CTL_W = FIELD_W * N_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               op_excl,
    input  logic               is_write,
    input  logic [CAUSE_W-1:0] xlat_code,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic [1:0]         cache_attr,
    input  logic               dcache_present,
    input  logic [CTL_W-1:0]   atom_ctl,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output logic [CAUSE_W-1:0] rsp_cause
);
    typedef struct packed {
        logic               valid;
        logic               allow;
        logic [CAUSE_W-1:0] cause;
    } rsp_t;

    rsp_t               rsp_d, rsp_q;
    logic               field_zero, is_isolate;
    logic               chk_allow;
    logic [CAUSE_W-1:0] chk_cause;
    logic               unused_wr;

    // Translation already folded the write flag in; the checker ignores it (R4)
    assign unused_wr = is_write;

    atom_field_sel #(
        .FIELD_W (FIELD_W),
        .N_FIELDS(N_FIELDS)
    ) u_sel (
        .cache_attr    (cache_attr),
        .dcache_present(dcache_present),
        .atom_ctl      (atom_ctl),
        .field_zero    (field_zero),
        .is_isolate    (is_isolate)
    );

    atom_fault_pri #(
        .CAUSE_W        (CAUSE_W),
        .CAUSE_LS_ERR   (CAUSE_LS_ERR),
        .CAUSE_ST_PROHIB(CAUSE_ST_PROHIB),
        .CAUSE_EXCL_ERR (CAUSE_EXCL_ERR)
    ) u_pri (
        .op_excl   (op_excl),
        .xlat_code (xlat_code),
        .perm_rd   (perm_rd),
        .perm_wr   (perm_wr),
        .field_zero(field_zero),
        .is_isolate(is_isolate),
        .allow     (chk_allow),
        .cause     (chk_cause)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.allow = chk_allow;
            rsp_d.cause = chk_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign rsp_cause = rsp_q.cause;

    assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_xlat_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlat_code != '0) |=> (!rsp_allow && rsp_cause == $past(xlat_code)));
    assert_isolate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlat_code == '0 && dcache_present && cache_attr == 2'b11 &&
         (op_excl || (perm_rd && perm_wr)))
        |=> (!rsp_allow && rsp_cause == CAUSE_LS_ERR));
    assert_allow_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_valid && rsp_cause == '0));
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && rsp_cause == '0));
endmodule

// File: tb/atom_perm_chk_tb.sv
module atom_perm_chk_tb;
    localparam int CW = 7;
    localparam logic [CW-1:0] LSE = 7'd3;
    localparam logic [CW-1:0] STP = 7'd29;
    localparam logic [CW-1:0] EXE = 7'd70;

    typedef struct {
        logic          allow;
        logic [CW-1:0] cause;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          op_excl = 1'b0;
    logic          is_write = 1'b0;
    logic [CW-1:0] xlat_code = '0;
    logic          perm_rd = 1'b0;
    logic          perm_wr = 1'b0;
    logic [1:0]    cache_attr = '0;
    logic          dcache_present = 1'b0;
    logic [5:0]    atom_ctl = '0;
    logic          rsp_valid, rsp_allow;
    logic [CW-1:0] rsp_cause;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    atom_perm_chk #(
        .FIELD_W(2), .N_FIELDS(3), .CAUSE_W(CW),
        .CAUSE_LS_ERR(LSE), .CAUSE_ST_PROHIB(STP), .CAUSE_EXCL_ERR(EXE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_excl(op_excl),
        .is_write(is_write), .xlat_code(xlat_code), .perm_rd(perm_rd),
        .perm_wr(perm_wr), .cache_attr(cache_attr), .dcache_present(dcache_present),
        .atom_ctl(atom_ctl), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_cause(rsp_cause)
    );

    function automatic exp_t model(input logic op, input logic dc, input logic [1:0] at,
                                   input logic [5:0] ctl, input logic rd, input logic wr,
                                   input logic [CW-1:0] xl);
        exp_t e;
        logic [1:0] ea;
        logic [1:0] f;
        e.allow = 1'b0;
        e.cause = '0;
        ea = dc ? at : 2'd0;
        f  = 2'((ctl >> (2 * ea)) & 6'd3);
        if (xl != '0) begin
            e.cause = xl; e.tag = "R2";
        end else if (!op && !(rd && wr)) begin
            e.cause = STP; e.tag = "R3";
        end else if (ea == 2'd3) begin
            e.cause = LSE; e.tag = "R7";
        end else if (f == 2'd0) begin
            e.cause = op ? EXE : LSE;
            e.tag = !dc ? "R8/R6" : "R6";
        end else begin
            e.allow = 1'b1;
            e.tag = (op && !(rd && wr)) ? "R4" : (!dc ? "R8/R9" : "R5/R9");
        end
        return e;
    endfunction

    task automatic send(input logic op, input logic dc, input logic [1:0] at,
                        input logic [5:0] ctl, input logic rd, input logic wr,
                        input logic [CW-1:0] xl, input logic w);
        @(negedge clk);
        req_valid = 1'b1; op_excl = op; dcache_present = dc; cache_attr = at;
        atom_ctl = ctl; perm_rd = rd; perm_wr = wr; xlat_code = xl; is_write = w;
        sb.push_back(model(op, dc, at, ctl, rd, wr, xl));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        xlat_code = 7'h55; cache_attr = 2'd2; atom_ctl = 6'h3f; perm_rd = 1; perm_wr = 1;
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R1: response with no request, allow=%0d cause=%0d expected none",
                             rsp_allow, rsp_cause);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rsp_allow !== e.allow || rsp_cause !== e.cause) begin
                        errors++;
                        $display("FAIL %s: allow=%0d cause=%0d expected allow=%0d cause=%0d",
                                 e.tag, rsp_allow, rsp_cause, e.allow, e.cause);
                    end
                end
            end else begin
                if (sb.size() != 0) begin
                    errors++;
                    $display("FAIL R1: valid=0 with %0d pending, expected valid=1", sb.size());
                    void'(sb.pop_front());
                end else if (rsp_allow !== 1'b0 || rsp_cause !== '0) begin
                    errors++;
                    $display("FAIL R10: idle allow=%0d cause=%0d expected 0/0", rsp_allow, rsp_cause);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_cause !== '0) begin
            errors++;
            $display("FAIL R1: reset valid=%0d allow=%0d cause=%0d expected 0/0/0",
                     rsp_valid, rsp_allow, rsp_cause);
        end
        @(negedge clk) rst_n = 1'b1;

        // R2: translation code wins even over isolate and bad permissions
        send(0, 1, 2'd3, 6'h00, 0, 0, 7'd1, 1);
        send(1, 1, 2'd0, 6'h3f, 1, 1, 7'd127, 0);
        send(0, 0, 2'd1, 6'h15, 1, 1, 7'd64, 1);
        idle();
        // R3: conditional store permission faults
        send(0, 1, 2'd0, 6'h3f, 1, 0, '0, 1);
        send(0, 1, 2'd0, 6'h3f, 0, 1, '0, 0);
        // R5: field selection, one nonzero field at a time
        send(0, 1, 2'd0, 6'h01, 1, 1, '0, 1);
        send(0, 1, 2'd1, 6'h01, 1, 1, '0, 1);
        send(1, 1, 2'd1, 6'h08, 0, 0, '0, 0);
        send(1, 1, 2'd2, 6'h08, 1, 0, '0, 1);
        send(1, 1, 2'd2, 6'h20, 0, 1, '0, 0);
        idle();
        // R7 / R8: isolate with and without cache
        send(1, 1, 2'd3, 6'h3f, 1, 1, '0, 0);
        send(1, 0, 2'd3, 6'h3c, 1, 1, '0, 0);
        send(0, 0, 2'd3, 6'h02, 1, 1, '0, 1);

        // Full sweep
        for (int op = 0; op < 2; op++)
            for (int dc = 0; dc < 2; dc++)
                for (int at = 0; at < 4; at++)
                    for (int c = 0; c < 64; c++)
                        for (int p = 0; p < 4; p++) begin
                            send(1'(op), 1'(dc), 2'(at), 6'(c), p[1], p[0], '0, 1'(c ^ p));
                            if (((c + p) % 11) == 0) idle();
                        end

        // Random translation codes
        for (int k = 0; k < 40; k++)
            send(1'(k), 1'(k >> 1), 2'(k), 6'(k * 7), 1'(k >> 2), 1'(k >> 3),
                 7'(k * 13 + 1), 1'(k >> 4));
        idle();
        idle();
        idle();
        done = 1'b1;
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R1: %0d responses missing, expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule